// File: doc/BRIEF.md
# Timer Status Flag Register

This block holds the sticky event flags of a general-purpose timer that has two capture/compare channels and four further event sources: update, commutation, trigger and break. The counter, the compare logic and the capture logic sit outside the block. They report to it through one-cycle strobes and a few control levels. Each strobe that passes its qualifying conditions sets a flag. The flag then stays set until software clears it.

Software reads a 32-bit status word. It clears a flag by writing 0 to that flag's bit, and bits written as 1 are left alone. When a channel is in input-capture mode, a read of that channel's capture register also clears the channel's flag. An overcapture flag records that a capture arrived while the channel flag was still set. The interrupt request is the OR of every flag masked by an enable vector. Flags change on the clock edge after the strobe, so they are visible one cycle later.

Top module: `tmr_stat_flags`

## Requirements
- R1: Flag positions in `status` are: update 0, channel-1 flag 1, channel-2 flag 2, commutation 5, trigger 6, break 7, channel-1 overcapture 9, channel-2 overcapture 10. Every other bit reads 0. All flags are 0 after reset.
- R2: A counter overflow strobe sets the update flag only when `repZero`=1 and `udis`=0.
- R3: A software update strobe or a trigger reinit strobe sets the update flag only when `urs`=0 and `udis`=0.
- R4: A channel in output mode (`chInMode` bit 0) sets its flag on a compare match strobe. If `ccrAboveArr` is set for that channel, it sets its flag on the overflow strobe instead.
- R5: A channel in input mode (`chInMode` bit 1) sets its flag on a capture strobe. A compare match strobe has no effect on a channel in input mode, and a capture strobe has no effect on a channel in output mode.
- R6: A capture-register read strobe clears a channel flag only when that channel is in input mode. The read leaves the channel's overcapture flag unchanged.
- R7: A channel's overcapture flag is set when a capture strobe arrives in input mode while that channel's flag is already 1. Output-mode events never set it.
- R8: The break flag is set in every cycle that `brkIn` is 1. A software clear of the break flag takes effect only while `brkIn` is 0.
- R9: When `slaveEn`=1 and `gatedMode`=0, the trigger flag is set by `trgRise` only. When `slaveEn`=1 and `gatedMode`=1, it is set by either `trgRise` or `trgFall`. When `slaveEn`=0 it is never set.
- R10: A commutation strobe sets the commutation flag.
- R11: A write with `wrEn`=1 clears every flag whose `wrData` bit is 0. Flags whose `wrData` bit is 1 are left unchanged.
- R12: If a set and a clear (write or capture-register read) reach the same flag in the same cycle, the flag ends up 1.
- R13: `irq` is 1 exactly when some status bit is 1 and the same bit of `irqEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ovfEvt | input | 1 | Counter overflow or underflow strobe |
| repZero | input | 1 | Repetition count has reached zero |
| ugEvt | input | 1 | Software-generated update strobe |
| trgReinit | input | 1 | Counter reinitialised by trigger strobe |
| urs | input | 1 | Restrict update flag to overflow only |
| udis | input | 1 | Update events disabled |
| chInMode | input | 2 | Per channel: 1 = input capture, 0 = output compare |
| cmpMatch | input | 2 | Per channel compare match strobe |
| ccrAboveArr | input | 2 | Per channel: compare value exceeds the reload value |
| capEvt | input | 2 | Per channel capture strobe |
| ccrRead | input | 2 | Per channel capture-register read strobe |
| comEvt | input | 1 | Commutation strobe |
| slaveEn | input | 1 | Slave controller enabled |
| gatedMode | input | 1 | Slave controller in gated mode |
| trgRise | input | 1 | Active trigger edge strobe |
| trgFall | input | 1 | Opposite trigger edge strobe |
| brkIn | input | 1 | Break input level, active high |
| wrEn | input | 1 | Status write strobe |
| wrData | input | 32 | Status write data; a 0 clears the flag at that bit |
| irqEn | input | 32 | Interrupt enable, one bit per status bit |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The update flag is driven with each combination of overflow, software update and trigger reinit against the `urs`, `udis` and `repZero` levels. This separates the two qualification rules. Both channels run in each mode with compare, capture, overflow and read strobes. Strobes that should be ignored are included, which shows that the mode gates both set and read-clear. Repeated captures, and captures that coincide with a read or a write, show the overcapture flag and set-over-clear priority. The break input is held active against clears and then released. The trigger edges are replayed with and without gated mode and with the slave controller disabled.

// File: rtl/tmr_stat_pkg.sv
`timescale 1ns/1ps
package tmr_stat_pkg;
  localparam int STAT_W  = 32;
  localparam int NUM_CH  = 2;
  // bit positions decoded by software
  localparam int UPD_BIT = 0;
  localparam int CC_BIT0 = 1;
  localparam int COM_BIT = 5;
  localparam int TRG_BIT = 6;
  localparam int BRK_BIT = 7;
  localparam int OVC_BIT0 = 9;

  typedef struct packed {
    logic              setUpd;
    logic [NUM_CH-1:0] setCc;
    logic [NUM_CH-1:0] capIn;
    logic [NUM_CH-1:0] clrCcRd;
    logic              setCom;
    logic              setTrg;
    logic              setBrk;
    logic              brkHeld;
  } flagStb_t;
endpackage

// File: rtl/tmr_stat_ctrl.sv
`timescale 1ns/1ps
module tmr_stat_ctrl
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ovfEvt,
  input  logic              repZero,
  input  logic              ugEvt,
  input  logic              trgReinit,
  input  logic              urs,
  input  logic              udis,
  input  logic [NUM_CH-1:0] chInMode,
  input  logic [NUM_CH-1:0] cmpMatch,
  input  logic [NUM_CH-1:0] ccrAboveArr,
  input  logic [NUM_CH-1:0] capEvt,
  input  logic [NUM_CH-1:0] ccrRead,
  input  logic              comEvt,
  input  logic              slaveEn,
  input  logic              gatedMode,
  input  logic              trgRise,
  input  logic              trgFall,
  input  logic              brkIn,
  output flagStb_t          stb
);
  logic ovfUpd;
  logic swUpd;
  logic [NUM_CH-1:0] outSet;
  logic [NUM_CH-1:0] inSet;

  // update qualification: overflow path and reinit path differ
  assign ovfUpd = ovfEvt & repZero & ~udis;
  assign swUpd  = (ugEvt | trgReinit) & ~urs & ~udis;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign outSet[ch] = ~chInMode[ch] &
                        (cmpMatch[ch] | (ccrAboveArr[ch] & ovfEvt));
    assign inSet[ch]  = chInMode[ch] & capEvt[ch];
  end

  always_comb begin
    stb         = '0;
    stb.setUpd  = ovfUpd | swUpd;
    stb.setCc   = outSet | inSet;
    stb.capIn   = inSet;
    stb.clrCcRd = chInMode & ccrRead;
    stb.setCom  = comEvt;
    stb.setTrg  = slaveEn & (trgRise | (gatedMode & trgFall));
    stb.setBrk  = brkIn;
    stb.brkHeld = brkIn;
  end

  AST_UPD_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.setUpd |-> !udis); // R2

endmodule

// File: rtl/tmr_stat_dp.sv
`timescale 1ns/1ps
module tmr_stat_dp
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStb_t          stb,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] irqEn,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [STAT_W-1:0] CC_MASK  = STAT_W'(((1 << NUM_CH) - 1) << CC_BIT0);
  localparam logic [STAT_W-1:0] OVC_MASK = STAT_W'(((1 << NUM_CH) - 1) << OVC_BIT0);
  localparam logic [STAT_W-1:0] FLAG_MASK = CC_MASK | OVC_MASK |
    STAT_W'((1 << UPD_BIT) | (1 << COM_BIT) | (1 << TRG_BIT) | (1 << BRK_BIT));

  logic updQ, comQ, trgQ, brkQ;
  logic [NUM_CH-1:0] ccQ, ovcQ;
  logic [STAT_W-1:0] swClr;

  assign swClr = wrEn ? ~wrData : '0;

  // sticky flags: set term first so a colliding clear loses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updQ <= 1'b0;
      comQ <= 1'b0;
      trgQ <= 1'b0;
      brkQ <= 1'b0;
      ccQ  <= '0;
      ovcQ <= '0;
    end else begin
      updQ <= stb.setUpd | (updQ & ~swClr[UPD_BIT]);
      comQ <= stb.setCom | (comQ & ~swClr[COM_BIT]);
      trgQ <= stb.setTrg | (trgQ & ~swClr[TRG_BIT]);
      brkQ <= stb.setBrk | (brkQ & ~(swClr[BRK_BIT] & ~stb.brkHeld));
      for (int ch = 0; ch < NUM_CH; ch++) begin
        ccQ[ch]  <= stb.setCc[ch] |
                    (ccQ[ch] & ~swClr[CC_BIT0 + ch] & ~stb.clrCcRd[ch]);
        ovcQ[ch] <= (stb.capIn[ch] & ccQ[ch]) |
                    (ovcQ[ch] & ~swClr[OVC_BIT0 + ch]);
      end
    end
  end

  always_comb begin
    status          = '0;
    status[UPD_BIT] = updQ;
    status[COM_BIT] = comQ;
    status[TRG_BIT] = trgQ;
    status[BRK_BIT] = brkQ;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      status[CC_BIT0 + ch]  = ccQ[ch];
      status[OVC_BIT0 + ch] = ovcQ[ch];
    end
  end

  assign irq = |(status & irqEn);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~FLAG_MASK) == '0); // R1

  AST_BRK_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.brkHeld |=> status[BRK_BIT]); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.setUpd |=> status[UPD_BIT]); // R12

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    AST_OVC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovcQ[ch]) |-> $past(stb.capIn[ch])); // R7
  end

endmodule

// File: rtl/tmr_stat_flags.sv
`timescale 1ns/1ps
module tmr_stat_flags
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ovfEvt,
  input  logic              repZero,
  input  logic              ugEvt,
  input  logic              trgReinit,
  input  logic              urs,
  input  logic              udis,
  input  logic [NUM_CH-1:0] chInMode,
  input  logic [NUM_CH-1:0] cmpMatch,
  input  logic [NUM_CH-1:0] ccrAboveArr,
  input  logic [NUM_CH-1:0] capEvt,
  input  logic [NUM_CH-1:0] ccrRead,
  input  logic              comEvt,
  input  logic              slaveEn,
  input  logic              gatedMode,
  input  logic              trgRise,
  input  logic              trgFall,
  input  logic              brkIn,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] irqEn,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  flagStb_t stb;

  tmr_stat_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ovfEvt(ovfEvt), .repZero(repZero),
    .ugEvt(ugEvt), .trgReinit(trgReinit), .urs(urs), .udis(udis),
    .chInMode(chInMode), .cmpMatch(cmpMatch), .ccrAboveArr(ccrAboveArr),
    .capEvt(capEvt), .ccrRead(ccrRead), .comEvt(comEvt),
    .slaveEn(slaveEn), .gatedMode(gatedMode), .trgRise(trgRise),
    .trgFall(trgFall), .brkIn(brkIn), .stb(stb)
  );

  tmr_stat_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrData(wrData),
    .irqEn(irqEn), .status(status), .irq(irq)
  );

endmodule

// File: tb/test_tmr_stat_flags.sv
`timescale 1ns/1ps
module test_tmr_stat_flags;
  localparam logic [31:0] U  = 32'h001, C1 = 32'h002, C2 = 32'h004;
  localparam logic [31:0] CM = 32'h020, TG = 32'h040, BK = 32'h080;
  localparam logic [31:0] O1 = 32'h200, O2 = 32'h400;

  typedef struct {
    logic [31:0] st;
    logic        irq;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN;
  logic ovfEvt, repZero, ugEvt, trgReinit, urs, udis;
  logic [1:0] chInMode, cmpMatch, ccrAboveArr, capEvt, ccrRead;
  logic comEvt, slaveEn, gatedMode, trgRise, trgFall, brkIn, wrEn;
  logic [31:0] wrData, irqEn, status;
  logic irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  expItem_t sb[$];
  expItem_t got;

  always #2 clk = ~clk;

  tmr_stat_flags i_tmr_stat_flags (
    .clk(clk), .rstN(rstN), .ovfEvt(ovfEvt), .repZero(repZero),
    .ugEvt(ugEvt), .trgReinit(trgReinit), .urs(urs), .udis(udis),
    .chInMode(chInMode), .cmpMatch(cmpMatch), .ccrAboveArr(ccrAboveArr),
    .capEvt(capEvt), .ccrRead(ccrRead), .comEvt(comEvt),
    .slaveEn(slaveEn), .gatedMode(gatedMode), .trgRise(trgRise),
    .trgFall(trgFall), .brkIn(brkIn), .wrEn(wrEn), .wrData(wrData),
    .irqEn(irqEn), .status(status), .irq(irq)
  );

  task automatic idlePulses();
    ovfEvt = 0; ugEvt = 0; trgReinit = 0; cmpMatch = 0; capEvt = 0;
    ccrRead = 0; comEvt = 0; trgRise = 0; trgFall = 0; wrEn = 0; wrData = '0;
  endtask

  // driver: stimulus already applied; push expectation, advance one cycle
  task automatic cyc(input logic [31:0] exp, input string tag);
    expItem_t it;
    it.st = exp;
    it.irq = |(exp & irqEn);
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    idlePulses();
  endtask

  task automatic clearTo(input logic [31:0] exp, input string tag);
    wrEn = 1; wrData = '0;
    cyc(exp, tag);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      got = sb.pop_front();
      nChecks++;
      if (status !== got.st || irq !== got.irq) begin
        nErrors++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                 got.tag, status, irq, got.st, got.irq);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    rstN = 0; idlePulses();
    repZero = 0; urs = 0; udis = 0; chInMode = 0; ccrAboveArr = 0;
    slaveEn = 0; gatedMode = 0; brkIn = 0; irqEn = '0;
    repeat (3) @(negedge clk);
    nChecks++;
    if (status !== 32'h0 || irq !== 1'b0) begin
      nErrors++;
      $display("FAIL R1 reset: status=%h irq=%b expected status=0 irq=0", status, irq);
    end
    rstN = 1;
    @(negedge clk);

    // R2 overflow qualification
    ovfEvt = 1; repZero = 0; cyc(0, "R2 ovf without repZero");
    ovfEvt = 1; repZero = 1; udis = 1; cyc(0, "R2 ovf with udis");
    udis = 0; ovfEvt = 1; cyc(U, "R2 ovf qualified");
    clearTo(0, "R11 write zero clears");
    // R3 software update / trigger reinit
    urs = 1; ugEvt = 1; cyc(0, "R3 ug with urs");
    trgReinit = 1; cyc(0, "R3 reinit with urs");
    urs = 0; udis = 1; trgReinit = 1; cyc(0, "R3 reinit with udis");
    udis = 0; ugEvt = 1; cyc(U, "R3 ug qualified");
    clearTo(0, "R11 clear");
    trgReinit = 1; cyc(U, "R3 reinit qualified");
    urs = 1; ovfEvt = 1; cyc(U, "R2 ovf still sets with urs");
    urs = 0; repZero = 0;
    wrEn = 1; wrData = '1; cyc(U, "R11 write ones keep");
    wrEn = 1; wrData = ~U; cyc(0, "R11 write zero bit0");

    // R4 output mode
    cmpMatch = 2'b01; cyc(C1, "R4 match ch1");
    ccrAboveArr = 2'b10; cmpMatch = 0; ovfEvt = 1; cyc(C1 | C2, "R4 overflow ch2 above");
    ccrRead = 2'b11; cyc(C1 | C2, "R6 read ignored in output mode");
    cmpMatch = 2'b01; cyc(C1 | C2, "R7 no overcapture in output mode");
    capEvt = 2'b11; cyc(C1 | C2, "R5 capture ignored in output mode");
    ccrAboveArr = 0;
    clearTo(0, "R11 clear");
    ovfEvt = 1; cyc(0, "R4 overflow without above flag");

    // R5..R7 input mode
    chInMode = 2'b11;
    cmpMatch = 2'b10; cyc(0, "R5 match ignored in input mode");
    capEvt = 2'b01; cyc(C1, "R5 capture ch1");
    capEvt = 2'b01; cyc(C1 | O1, "R7 overcapture ch1");
    capEvt = 2'b10; cyc(C1 | C2 | O1, "R5 capture ch2");
    ccrRead = 2'b10; cyc(C1 | O1, "R6 read clears ch2");
    ccrRead = 2'b01; cyc(O1, "R6 read keeps overcapture");
    wrEn = 1; wrData = ~O1; cyc(0, "R11 clear overcapture");
    capEvt = 2'b10; ccrRead = 2'b10; cyc(C2, "R12 capture beats read");
    capEvt = 2'b10; wrEn = 1; wrData = '0; cyc(C2 | O2, "R12 capture beats write, R7");
    clearTo(0, "R11 clear");
    chInMode = 2'b00;

    // R8 break
    brkIn = 1; cyc(BK, "R8 break sets");
    wrEn = 1; wrData = '0; cyc(BK, "R8 clear blocked while active");
    brkIn = 0; cyc(BK, "R8 flag sticks after release");
    clearTo(0, "R8 clear when inactive");

    // R9 trigger
    trgRise = 1; trgFall = 1; cyc(0, "R9 slave disabled");
    slaveEn = 1; trgFall = 1; cyc(0, "R9 fall ignored non-gated");
    trgRise = 1; cyc(TG, "R9 rise non-gated");
    clearTo(0, "R11 clear");
    gatedMode = 1; trgFall = 1; cyc(TG, "R9 fall gated");
    clearTo(0, "R11 clear");
    trgRise = 1; cyc(TG, "R9 rise gated");
    clearTo(0, "R11 clear");
    slaveEn = 0; gatedMode = 0;

    // R10 commutation, R13 interrupt
    comEvt = 1; cyc(CM, "R10 commutation");
    cyc(CM, "R13 no enable no irq");
    irqEn = CM; cyc(CM, "R13 enabled irq");
    irqEn = TG | U; cyc(CM, "R13 other enables no irq");
    irqEn = 32'hFFFF_F800; cyc(CM, "R13 unused enables no irq");
    irqEn = TG; trgRise = 1; slaveEn = 1; cyc(CM | TG, "R13 trigger irq");
    slaveEn = 0;
    clearTo(0, "R13 irq drops after clear");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule